// File: doc/BRIEF.md
# Dual-Target Rail Ramp Sequencer

This block steers the output codes of three independent voltage rails. Each rail has two preset target codes on its inputs. It also has a pair of control bits held in one control byte, which is written over a simple register-write bus. The select bit picks which of the two targets applies. The go bit launches a ramp toward it. Changing a rail's level therefore takes two actions together: choose the target, then start.

While a ramp runs, the rail's code moves by one LSB on each pulse of the ramp-rate enable `step_tick_i`. It moves up or down, whichever way reaches the target. The ramp ends when the code equals the target, and the rail's go state then clears itself. A busy flag per rail shows when a ramp is in progress. When a rail is not ramping it holds its code, whatever the target inputs or the tick do.

Top module: `ramp_seq_top`

## Requirements
- R1: After synchronous reset every rail code equals `INIT_CODE` (default 16) and every busy flag is 0.
- R2: A write whose address is not 0x20 changes no rail code and no busy flag.
- R3: Control byte at 0x20: for rail r, bit 2r is select and bit 2r+1 is go. A write with go=1 to an idle rail ramps it to target A when select is 0, and to target B when select is 1, never passing beyond the target.
- R4: During a ramp the code changes by exactly one LSB on each clock edge where `step_tick_i` is high and does not change on edges where it is low.
- R5: Busy rises in the cycle after the go write and falls in the cycle after the code reaches the target; the go state then needs no further write to clear.
- R6: A control write to a rail that is busy alters neither its latched target nor its progress.
- R7: Rails are independent: a go write to one rail leaves the other rails' busy flags and codes unaffected, and several rails can ramp at once.
- R8: Bits 7 and 6 of the control byte are reserved; setting them has no effect.
- R9: A go write whose selected target already equals the code raises busy for exactly one cycle and leaves the code unchanged.
- R10: An idle rail keeps its code regardless of ticks or changes on its target inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | REG_W | Register write data |
| step_tick_i | input | 1 | Ramp-rate enable, one step per high cycle |
| tgt_a_i | input | RAILS*CODE_W | Target A per rail, rail r at bits [r*CODE_W +: CODE_W] |
| tgt_b_i | input | RAILS*CODE_W | Target B per rail, same packing |
| code_o | output | RAILS*CODE_W | Present code per rail |
| busy_o | output | RAILS | Ramp in progress per rail |

## Verification
The bench ramps a rail upward under select 0 and downward under select 1. A design that decoded the select bit inverted, or stepped only one way, would stop at the wrong code. It spaces the ticks apart and holds gaps between them. Stepping on every clock, or by more than one LSB, would then show up as an early code.

A re-issued go in the middle of a ramp is checked: a design that retargeted would end at target A instead of B. A go whose target already equals the code is also checked, since a design that never cleared would stay busy. Two rails ramp together with different distances, so that busy flags tied together would drop at the same time. Reserved-bit writes, writes to the wrong address and changes of the target inputs while a rail is idle must all leave every code where it was.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int ADDR_W    = 8;
  localparam int REG_W     = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h20;
  localparam int BITS_PER_RAIL = 2;
  localparam int SEL_OFS   = 0;
  localparam int GO_OFS    = 1;

  typedef struct packed {
    logic sel;
    logic go;
  } rail_cmd_t;
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ramp_pkg::*;
#(
  parameter int RAILS = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              hit_o,
  output rail_cmd_t [RAILS-1:0] cmd_o
);
  localparam int USED_W = RAILS * BITS_PER_RAIL;

  initial begin
    if (USED_W > REG_W) $error("control byte too narrow for rail count");
  end

  assign hit_o = wr_en_i && (wr_addr_i == CTRL_ADDR);

  for (genvar r = 0; r < RAILS; r++) begin : g_field
    assign cmd_o[r].sel = wr_data_i[r*BITS_PER_RAIL + SEL_OFS];
    assign cmd_o[r].go  = wr_data_i[r*BITS_PER_RAIL + GO_OFS];
  end

  if (USED_W < REG_W) begin : g_rsvd
    logic unused_rsvd;
    assign unused_rsvd = ^wr_data_i[REG_W-1:USED_W];
  end
endmodule

// File: rtl/ramp_step.sv
module ramp_step #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] cur_i,
  input  logic [CODE_W-1:0] tgt_i,
  input  logic              en_i,
  output logic [CODE_W-1:0] nxt_o,
  output logic              at_tgt_o
);
  always_comb begin
    at_tgt_o = (cur_i == tgt_i);
    nxt_o    = cur_i;
    if (en_i && !at_tgt_o) begin
      if (cur_i < tgt_i) nxt_o = cur_i + 1'b1;
      else               nxt_o = cur_i - 1'b1;
    end
  end
endmodule

// File: rtl/rail_ramp.sv
module rail_ramp
  import ramp_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] INIT_CODE = 6'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  rail_cmd_t         cmd_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] tgt_a_i,
  input  logic [CODE_W-1:0] tgt_b_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] code_q, tgt_q, code_nxt;
  logic              go_q, at_tgt, start;

  assign start = hit_i && cmd_i.go && !go_q;

  ramp_step #(.CODE_W(CODE_W)) i_step (
    .cur_i   (code_q),
    .tgt_i   (tgt_q),
    .en_i    (go_q && tick_i),
    .nxt_o   (code_nxt),
    .at_tgt_o(at_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      tgt_q  <= INIT_CODE;
      code_q <= INIT_CODE;
    end else begin
      code_q <= code_nxt;
      if (start) begin
        go_q  <= 1'b1;
        tgt_q <= cmd_i.sel ? tgt_b_i : tgt_a_i;
      end else if (go_q && at_tgt) begin
        go_q <= 1'b0;
      end
    end
  end

  assign code_o = code_q;
  assign busy_o = go_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 || code_q == $past(code_q) - 1'b1)); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(code_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(code_q)); // R10
  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
    (busy_o && code_q < tgt_q) |=> code_q <= tgt_q); // R3
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (busy_o && code_q == tgt_q) |=> !busy_o); // R5
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && hit_i) |=> $stable(tgt_q)); // R6
endmodule

// File: rtl/ramp_seq_top.sv
module ramp_seq_top
  import ramp_pkg::*;
#(
  parameter int RAILS  = 3,
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] INIT_CODE = 6'd16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [REG_W-1:0]        wr_data_i,
  input  logic                    step_tick_i,
  input  logic [RAILS*CODE_W-1:0] tgt_a_i,
  input  logic [RAILS*CODE_W-1:0] tgt_b_i,
  output logic [RAILS*CODE_W-1:0] code_o,
  output logic [RAILS-1:0]        busy_o
);
  logic                  hit;
  rail_cmd_t [RAILS-1:0] cmd;

  ctrl_decode #(.RAILS(RAILS)) i_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .hit_o    (hit),
    .cmd_o    (cmd)
  );

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    rail_ramp #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) i_rail (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit),
      .cmd_i  (cmd[r]),
      .tick_i (step_tick_i),
      .tgt_a_i(tgt_a_i[r*CODE_W +: CODE_W]),
      .tgt_b_i(tgt_b_i[r*CODE_W +: CODE_W]),
      .code_o (code_o[r*CODE_W +: CODE_W]),
      .busy_o (busy_o[r])
    );
  end
endmodule

// File: tb/test_ramp_seq_top.sv
module test_ramp_seq_top;
  localparam int RAILS = 3;
  localparam int CW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic step_tick_i = 1'b0;
  logic [RAILS*CW-1:0] tgt_a_i = {6'd10, 6'd16, 6'd20};
  logic [RAILS*CW-1:0] tgt_b_i = {6'd18, 6'd30, 6'd12};
  logic [RAILS*CW-1:0] code_o;
  logic [RAILS-1:0]    busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ramp_seq_top i_ramp_seq_top (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .step_tick_i(step_tick_i),
    .tgt_a_i(tgt_a_i), .tgt_b_i(tgt_b_i), .code_o(code_o), .busy_o(busy_o)
  );

  function automatic int code_of(int r);
    return int'(code_o[r*CW +: CW]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      step_tick_i = 1'b1;
      @(negedge clk);
      step_tick_i = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int r = 0; r < RAILS; r++) chk("R1 code", code_of(r), 16);
    chk("R1 busy", int'(busy_o), 0);
  endtask

  task automatic t_wrong_addr();
    wr(8'h21, 8'hFF);
    chk("R2 busy", int'(busy_o), 0);
    ticks(3);
    for (int r = 0; r < RAILS; r++) chk("R2 code", code_of(r), 16);
  endtask

  task automatic t_reserved();
    wr(8'h20, 8'hC0);
    chk("R8 busy", int'(busy_o), 0);
    ticks(2);
    for (int r = 0; r < RAILS; r++) chk("R8 code", code_of(r), 16);
  endtask

  task automatic t_up_sel0();
    wr(8'h20, 8'h02);
    chk("R5 busy rise", int'(busy_o), 1);
    chk("R7 others idle", int'(busy_o[2:1]), 0);
    idle(2);
    chk("R4 no tick", code_of(0), 16);
    ticks(1);
    chk("R4 one step", code_of(0), 17);
    ticks(3);
    chk("R3 target A", code_of(0), 20);
    chk("R5 busy at end", int'(busy_o[0]), 1);
    idle(1);
    chk("R5 busy fall", int'(busy_o[0]), 0);
    ticks(3);
    chk("R10 hold", code_of(0), 20);
    chk("R7 rail1", code_of(1), 16);
  endtask

  task automatic t_down_sel1();
    wr(8'h20, 8'h03);
    ticks(2);
    chk("R4 down", code_of(0), 18);
    wr(8'h20, 8'h02);
    chk("R6 still busy", int'(busy_o[0]), 1);
    chk("R6 no jump", code_of(0), 18);
    ticks(6);
    chk("R6 target B kept", code_of(0), 12);
    idle(1);
    chk("R5 fall", int'(busy_o[0]), 0);
    wr(8'h20, 8'h02);
    ticks(8);
    chk("R3 back to A", code_of(0), 20);
    idle(1);
    chk("R5 fall 2", int'(busy_o[0]), 0);
  endtask

  task automatic t_equal();
    wr(8'h20, 8'h08);
    chk("R9 busy pulse", int'(busy_o[1]), 1);
    idle(1);
    chk("R9 busy clear", int'(busy_o[1]), 0);
    chk("R9 code", code_of(1), 16);
  endtask

  task automatic t_parallel();
    wr(8'h20, 8'h2C);
    chk("R7 both busy", int'(busy_o), 6);
    ticks(6);
    chk("R7 rail2", code_of(2), 10);
    chk("R7 rail1", code_of(1), 22);
    idle(1);
    chk("R7 busy split", int'(busy_o), 2);
    ticks(8);
    chk("R3 rail1 B", code_of(1), 30);
    idle(1);
    chk("R5 all idle", int'(busy_o), 0);
    chk("R7 rail0 untouched", code_of(0), 20);
  endtask

  task automatic t_target_change();
    tgt_a_i = {6'd1, 6'd2, 6'd3};
    tgt_b_i = {6'd4, 6'd5, 6'd6};
    ticks(3);
    chk("R10 rail0", code_of(0), 20);
    chk("R10 rail1", code_of(1), 30);
    chk("R10 rail2", code_of(2), 10);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_wrong_addr();
    t_reserved();
    t_up_sel0();
    t_down_sel1();
    t_equal();
    t_parallel();
    t_target_change();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule